// File: doc/BRIEF.md
# Column-Tiled Digital Gain

This block scales a 10-bit pixel stream with a gain that depends on the pixel's horizontal position. The width of a line is divided into five tile columns by programmable start columns. Each tile has its own gain code, in quarter steps, and its own 4-bit weight. The block counts columns along each line and finds the tile that holds the current pixel. It multiplies the pixel by that tile's gain, clips the product to ten bits, and passes the tile index and tile weight downstream for a later statistics stage.

A simple write port loads the settings. Addresses 1 to 4 hold the start columns of tiles 1 to 4. Tile 0 always starts at the first column of the line. The last tile runs to the end of the line. Addresses 8 to 12 hold the gain and weight of tiles 0 to 4. Every other address, including 0 and 5, is ignored. Results appear two clock cycles after the pixel enters.

Top module: `col_tile_gain`

## Requirements
- R1: After reset, out_valid is low. Every gain code is 4, every weight is 15, and the start columns of tiles 1 to 4 are 150, 300, 450 and 600.
- R2: A pixel presented with line_start high is column 0. Each later pixel with pix_valid high is one column further on. Cycles with pix_valid low do not advance the column. The column stops at 1023.
- R3: A pixel at column c is placed in the highest tile k in 1..4 whose start column is not above c. If there is no such tile, it goes to tile 0. out_tile carries k as a 3-bit number.
- R4: A column at or past the start of tile 4, including columns beyond 752, is placed in tile 4.
- R5: out_data equals (pixel × gain code) shifted right by 2, and is limited to 1023.
- R6: out_weight is the 4-bit weight of the tile the pixel falls in.
- R7: out_valid rises exactly two rising edges after the edge that samples pix_valid high. The results for that pixel are held together with it.
- R8: A write with cfg_we high goes to one of two places. At addresses 1 to 4, cfg_wdata sets the start column of that tile, and values above 752 are stored as 752. At address 8+k, bits 3:0 set the gain code of tile k and bits 7:4 set its weight. Writes to any other address change nothing.
- R9: With the reset gain code of 4, every pixel leaves unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 4 | Settings address |
| cfg_wdata | input | 10 | Settings write data |
| line_start | input | 1 | Marks the first pixel of a line |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_data | input | 10 | Input pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_data | output | 10 | Scaled and clipped pixel |
| out_tile | output | 3 | Tile index of the output pixel |
| out_weight | output | 4 | Weight of that tile |

## Verification
The assertions assume two things about the inputs. First, pix_valid is low while reset is held. Second, the settings do not change while pixels are still in the pipeline, so the result two edges later still matches the settings in force. The stimulus writes settings only after the pipeline has been idle for several cycles. It drives pixels only after reset is released. The expected values come from a model of the settings held in the bench, which is updated by the same write task.

// File: rtl/col_tile_gain.sv
module col_tile_gain #(
  parameter int PIX_W   = 10,
  parameter int COL_W   = 10,
  parameter int CODE_W  = 4,
  parameter int WT_W    = 4,
  parameter int N_TILES = 5,
  parameter int ADDR_W  = 4,
  parameter int X_STEP  = 150,
  parameter int X_MAX   = 752,
  parameter int FRAC    = 2,
  parameter int UNITY   = 4,
  parameter int GAIN_BASE = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [COL_W-1:0]           cfg_wdata,
  input  logic                       line_start,
  input  logic                       pix_valid,
  input  logic [PIX_W-1:0]           pix_data,
  output logic                       out_valid,
  output logic [PIX_W-1:0]           out_data,
  output logic [$clog2(N_TILES)-1:0] out_tile,
  output logic [WT_W-1:0]            out_weight
);
  localparam int TW    = $clog2(N_TILES);
  localparam int PW    = PIX_W + CODE_W;
  localparam logic [COL_W-1:0] COL_MAX = {COL_W{1'b1}};
  localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};

  logic [N_TILES-1:1][COL_W-1:0]  bnd;
  logic [N_TILES-1:0][CODE_W-1:0] gain;
  logic [N_TILES-1:0][WT_W-1:0]   wt;

  logic [COL_W-1:0] col_cnt;
  logic [COL_W-1:0] cur_col;
  logic [TW-1:0]    tile_sel;

  logic             s1_valid;
  logic [PIX_W-1:0] s1_pix;
  logic [TW-1:0]    s1_tile;

  logic [PW-1:0]    prod;
  logic [PW-1:0]    scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k < N_TILES; k++) bnd[k] <= COL_W'(k * X_STEP);
      for (int k = 0; k < N_TILES; k++) begin
        gain[k] <= CODE_W'(UNITY);
        wt[k]   <= {WT_W{1'b1}};
      end
    end else if (cfg_we) begin
      for (int k = 1; k < N_TILES; k++)
        if (cfg_addr == ADDR_W'(k))
          bnd[k] <= (cfg_wdata > COL_W'(X_MAX)) ? COL_W'(X_MAX) : cfg_wdata;
      for (int k = 0; k < N_TILES; k++)
        if (cfg_addr == ADDR_W'(GAIN_BASE + k)) begin
          gain[k] <= cfg_wdata[CODE_W-1:0];
          wt[k]   <= cfg_wdata[CODE_W +: WT_W];
        end
    end
  end

  assign cur_col = line_start ? '0 : col_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      col_cnt <= '0;
    else if (pix_valid)
      col_cnt <= (cur_col == COL_MAX) ? COL_MAX : cur_col + 1'b1;
    else if (line_start)
      col_cnt <= '0;
  end

  always_comb begin
    tile_sel = '0;
    for (int k = 1; k < N_TILES; k++)
      if (cur_col >= bnd[k]) tile_sel = TW'(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pix   <= '0;
      s1_tile  <= '0;
    end else begin
      s1_valid <= pix_valid;
      if (pix_valid) begin
        s1_pix  <= pix_data;
        s1_tile <= tile_sel;
      end
    end
  end

  assign prod   = PW'(s1_pix) * PW'(gain[s1_tile]);
  assign scaled = prod >> FRAC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_tile   <= '0;
      out_weight <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_data   <= (scaled > PW'(PIX_MAX)) ? PIX_MAX : scaled[PIX_W-1:0];
        out_tile   <= s1_tile;
        out_weight <= wt[s1_tile];
      end
    end
  end
endmodule

module col_tile_gain_chk #(
  parameter int PIX_W   = 10,
  parameter int COL_W   = 10,
  parameter int N_TILES = 5,
  parameter int X_MAX   = 752
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       line_start,
  input logic                       pix_valid,
  input logic [PIX_W-1:0]           pix_data,
  input logic                       out_valid,
  input logic [PIX_W-1:0]           out_data,
  input logic [$clog2(N_TILES)-1:0] out_tile,
  input logic [COL_W-1:0]           col_cnt,
  input logic [N_TILES-1:1][COL_W-1:0] bnd
);
  localparam logic [COL_W-1:0] COL_MAX = {COL_W{1'b1}};

  // R7
  lat_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_valid, 2));

  // R7
  lat_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(pix_valid, 2)) |-> out_valid);

  // R4
  tile_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tile < N_TILES));

  // R2
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_start && col_cnt != COL_MAX) |=> (col_cnt == $past(col_cnt) + 1'b1));

  // R5
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(pix_valid, 2) && $past(pix_data, 2) == '0) |-> (out_data == '0));

  for (genvar k = 1; k < N_TILES; k++) begin : g_bnd
    // R8
    bnd_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bnd[k] <= COL_W'(X_MAX));
  end
endmodule

bind col_tile_gain col_tile_gain_chk #(
  .PIX_W(PIX_W), .COL_W(COL_W), .N_TILES(N_TILES), .X_MAX(X_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_valid(pix_valid),
  .pix_data(pix_data), .out_valid(out_valid), .out_data(out_data),
  .out_tile(out_tile), .col_cnt(col_cnt), .bnd(bnd)
);

// File: tb/test_col_tile_gain.sv
module test_col_tile_gain;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [9:0] cfg_wdata = '0;
  logic       line_start = 1'b0;
  logic       pix_valid = 1'b0;
  logic [9:0] pix_data = '0;
  logic       out_valid;
  logic [9:0] out_data;
  logic [2:0] out_tile;
  logic [3:0] out_weight;

  col_tile_gain i_col_tile_gain (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .line_start(line_start), .pix_valid(pix_valid),
    .pix_data(pix_data), .out_valid(out_valid), .out_data(out_data),
    .out_tile(out_tile), .out_weight(out_weight)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  int m_bnd [1:4];
  int m_gain [0:4];
  int m_wt [0:4];
  int mcol = 0;

  int    q_data [$];
  int    q_tile [$];
  int    q_wt [$];
  int    q_due [$];
  string q_req [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 1; k < 5; k++) m_bnd[k] = 150 * k;
    for (int k = 0; k < 5; k++) begin m_gain[k] = 4; m_wt[k] = 15; end
    mcol = 0;
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 10'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr >= 1 && addr <= 4) m_bnd[addr] = (data > 752) ? 752 : data;
    if (addr >= 8 && addr <= 12) begin
      m_gain[addr-8] = data & 15;
      m_wt[addr-8] = (data >> 4) & 15;
    end
  endtask

  task automatic send(input bit vld, input bit ls, input int pix, input string req);
    int c, t, e;
    @(negedge clk);
    pix_valid = vld; line_start = ls; pix_data = 10'(pix);
    if (vld) begin
      c = ls ? 0 : mcol;
      mcol = (c == 1023) ? 1023 : c + 1;
      t = 0;
      for (int k = 1; k < 5; k++) if (c >= m_bnd[k]) t = k;
      e = (pix * m_gain[t]) >> 2;
      if (e > 1023) e = 1023;
      q_data.push_back(e); q_tile.push_back(t); q_wt.push_back(m_wt[t]);
      q_due.push_back(cyc + 2); q_req.push_back(req);
    end else if (ls) mcol = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(0, 0, 0, "");
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_data.size() == 0) check(0, "R7", 1, 0);
      else begin
        int ed, et, ew, eu;
        string r;
        ed = q_data.pop_front(); et = q_tile.pop_front(); ew = q_wt.pop_front();
        eu = q_due.pop_front(); r = q_req.pop_front();
        check(out_data == 10'(ed), r, out_data, ed);
        check(out_tile == 3'(et), "R3", out_tile, et);
        check(out_weight == 4'(ew), "R6", out_weight, ew);
        check(cyc == eu, "R7", cyc, eu);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);

    // R1 R9 R4: defaults, unity gain, gaps in valid, line longer than 752
    for (int i = 0; i < 800; i++) begin
      send(1, i == 0, (i * 37) % 1024, "R9");
      if (i % 7 == 3) send(0, 0, 0, "");
    end
    idle(4);
    check(q_data.size() == 0, "R7", q_data.size(), 0);

    // R5 R6 R8: new gains and weights, saturation
    cfg_write(8, 'h11);
    cfg_write(9, 'h2F);
    cfg_write(10, 'h38);
    cfg_write(11, 'h46);
    cfg_write(12, 'h5C);
    for (int i = 0; i < 760; i++)
      send(1, i == 0, (i % 3 == 0) ? 1023 : (i * 13) % 1024, "R5");
    idle(4);

    // R8 R3 R4: boundary rewrite with an over-range value
    cfg_write(1, 10);
    cfg_write(2, 20);
    cfg_write(3, 30);
    cfg_write(4, 1000);
    for (int i = 0; i < 780; i++) send(1, i == 0, 400 + (i % 200), "R8");
    idle(4);

    // R8: writes to unused addresses are ignored
    cfg_write(0, 500);
    cfg_write(5, 3);
    cfg_write(14, 'h3FF);
    cfg_write(7, 'h3FF);
    for (int i = 0; i < 770; i++) send(1, i == 0, 300 + i % 500, "R8");
    idle(4);

    // R2: short lines, restarts mid-line, start without valid
    for (int l = 0; l < 6; l++) begin
      for (int i = 0; i < 25 + l * 3; i++) begin
        send(1, i == 0, 100 + i, "R2");
        if (i % 5 == 2) send(0, 0, 0, "");
      end
    end
    send(0, 1, 0, "");
    for (int i = 0; i < 40; i++) send(1, 0, 200 + i, "R2");
    idle(4);

    // R2: column holds at 1023 on an over-long line
    for (int i = 0; i < 1100; i++) send(1, i == 0, 512, "R2");
    idle(4);
    check(q_data.size() == 0, "R7", q_data.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule